// File: doc/BRIEF.md
# Pending MSI Vector Scanner

When one of the coalesced message-signalled interrupt lines fires, this block finds out which vectors behind that line are pending. It accepts a group number on a request handshake. It reads the group's summary register through a one-at-a-time register-read master port. For every summary bit that is set, lowest first, it then reads the matching index register. For every set bit of that index register, lowest first, it emits one global vector number on a valid/ready stream. At the end it pulses a done flag and reports how many vectors it emitted.

Each found bit is turned into a global vector number by an interleaved formula. The index and bit form the upper part and the group forms the low part. The result is then rounded down to a multiple of a per-core count given on an input, so that a vector block shared by several cores always reports its base. The register bank and the later dispatch of interrupts sit outside the block.

States: `S_IDLE` (waiting for a request), `S_SUM_RD` (summary read outstanding), `S_PICK_IDX` (choose the lowest pending index), `S_IDX_RD` (index read outstanding), `S_PICK_BIT` (choose the lowest pending bit), `S_EMIT` (vector offered on the stream), `S_DONE` (completion pulse). The transitions are:
- `S_IDLE` to `S_SUM_RD` on an accepted request with a valid group.
- `S_IDLE` to `S_DONE` on an accepted request with an out-of-range group.
- `S_SUM_RD` to `S_PICK_IDX` on `rd_valid`.
- `S_PICK_IDX` to `S_IDX_RD` when a summary bit remains, and to `S_DONE` when none does.
- `S_IDX_RD` to `S_PICK_BIT` on `rd_valid`.
- `S_PICK_BIT` to `S_EMIT` when an index bit remains. When none does, it clears the summary bit locally and goes back to `S_PICK_IDX`.
- `S_EMIT` to `S_PICK_BIT` on `vec_ready`, clearing the bit locally.
- `S_DONE` to `S_IDLE` always.

Top module: `msi_pend_scan`

## Requirements
- R1: A request with `req_grp` of 16 or more is answered in the next cycle with `done`=1 and `done_count`=0. No read is issued and no vector is emitted.
- R2: For a valid group, the first read of the scan has `rd_is_sum`=1 and `rd_grp` equal to the requested group.
- R3: After the summary read, one index read is issued for each set summary bit x, in order of increasing x. Such a read has `rd_is_sum`=0, `rd_grp` equal to the group and `rd_idx`=x. An index register that reads as zero yields no vector.
- R4: Within one index register, one vector is emitted for each set bit b, in order of increasing b. The scan emits exactly as many vectors as there are set bits across the index registers it reads.
- R5: The raw vector number for group g, index x and bit b is ((x*16)+b)*16+g.
- R6: The emitted `vec_num` is the raw number rounded down to a multiple of `core_cnt`, where `core_cnt` is in the range 1 to 8 and a value of 0 is treated as 1.
- R7: While `vec_valid`=1 and `vec_ready`=0, the next cycle keeps `vec_valid`=1 with `vec_num` unchanged. No vector is dropped or repeated.
- R8: `rd_req` stays high, with `rd_is_sum`, `rd_grp` and `rd_idx` unchanged, until a cycle with `rd_valid`=1. Only one read is outstanding at a time, and no read is outstanding while a vector is offered.
- R9: Each scan ends with `done`=1 for exactly one cycle, with `done_count` equal to the number of vectors emitted. `req_ready` is 1 only in the idle state, including directly after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Scan request |
| req_ready | output | 1 | Scanner idle, request accepted this cycle |
| req_grp | input | GRP_IN_W (5) | Group to scan; values of NUM_GROUPS or more are out of range |
| core_cnt | input | CORE_W (4) | Per-core block size used for alignment, 1 to MAX_CORES |
| rd_req | output | 1 | Register read request, held until answered |
| rd_is_sum | output | 1 | 1: summary register, 0: index register |
| rd_grp | output | GRP_W (4) | Group of the register read |
| rd_idx | output | IDX_W (3) | Index of the register read (index reads only) |
| rd_valid | input | 1 | Read response valid |
| rd_data | input | RD_W (16) | Read response data |
| vec_valid | output | 1 | Vector number offered |
| vec_ready | input | 1 | Consumer accepts the vector |
| vec_num | output | VEC_W (11) | Aligned global vector number |
| done | output | 1 | One-cycle completion pulse |
| done_count | output | CNT_W (8) | Vectors emitted by the finished scan |

## Verification
The bench aims at a summary bit whose index register reads zero. A scanner that assumes the index register is non-empty would emit a garbage vector, or would fail to clear the summary bit and loop forever. A full group with all 128 bits set, together with core counts of 3 and 0, tests the alignment arithmetic at the widest raw numbers; a wrong modulo or divide-by-zero shows up as a wrong base. Long back-pressure and read latency tests whether a stalled vector is dropped, repeated or changed while the stream waits. Out-of-range groups 16 and 31 test that the scanner neither issues a read to a non-existent group nor hangs.

// File: rtl/msi_scan_pkg.sv
package msi_scan_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SUM_RD,
        S_PICK_IDX,
        S_IDX_RD,
        S_PICK_BIT,
        S_EMIT,
        S_DONE
    } scan_state_e;

endpackage

// File: rtl/msi_lsb_find.sv
// Lowest-set-bit finder: pos is the smallest i with vec[i] set.
module msi_lsb_find #(
    parameter int W = 16,
    localparam int PW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  vec,
    output logic          found,
    output logic [PW-1:0] pos
);
    always_comb begin
        found = |vec;
        pos   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) pos = PW'(i);
        end
    end
endmodule

// File: rtl/msi_vec_align.sv
// Interleaved vector number, then rounded down to a multiple of the core count.
module msi_vec_align #(
    parameter int NUM_GROUPS    = 16,
    parameter int IDX_PER_GROUP = 8,
    parameter int BITS_PER_IDX  = 16,
    parameter int MAX_CORES     = 8,
    localparam int GRP_W  = $clog2(NUM_GROUPS),
    localparam int IDX_W  = $clog2(IDX_PER_GROUP),
    localparam int BIT_W  = $clog2(BITS_PER_IDX),
    localparam int CORE_W = $clog2(MAX_CORES + 1),
    localparam int VEC_W  = $clog2(NUM_GROUPS * IDX_PER_GROUP * BITS_PER_IDX)
) (
    input  logic [GRP_W-1:0]  grp,
    input  logic [IDX_W-1:0]  idx,
    input  logic [BIT_W-1:0]  bitn,
    input  logic [CORE_W-1:0] core_cnt,
    output logic [VEC_W-1:0]  vec_num
);
    logic [VEC_W-1:0]  raw;
    logic [CORE_W-1:0] core_eff;
    logic [VEC_W-1:0]  rem;

    always_comb begin
        raw      = (VEC_W'(idx) * VEC_W'(BITS_PER_IDX) + VEC_W'(bitn))
                   * VEC_W'(NUM_GROUPS) + VEC_W'(grp);
        core_eff = (core_cnt == '0) ? CORE_W'(1) : core_cnt;
        rem      = raw % VEC_W'(core_eff);
        vec_num  = raw - rem;
    end
endmodule

// File: rtl/msi_pend_scan.sv
module msi_pend_scan
    import msi_scan_pkg::*;
#(
    parameter int NUM_GROUPS    = 16,
    parameter int IDX_PER_GROUP = 8,
    parameter int BITS_PER_IDX  = 16,
    parameter int MAX_CORES     = 8,
    parameter int GRP_IN_W      = 5,
    localparam int GRP_W  = $clog2(NUM_GROUPS),
    localparam int IDX_W  = $clog2(IDX_PER_GROUP),
    localparam int BIT_W  = $clog2(BITS_PER_IDX),
    localparam int CORE_W = $clog2(MAX_CORES + 1),
    localparam int VEC_W  = $clog2(NUM_GROUPS * IDX_PER_GROUP * BITS_PER_IDX),
    localparam int CNT_W  = $clog2(IDX_PER_GROUP * BITS_PER_IDX + 1),
    localparam int RD_W   = (IDX_PER_GROUP > BITS_PER_IDX) ? IDX_PER_GROUP : BITS_PER_IDX
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [GRP_IN_W-1:0] req_grp,
    input  logic [CORE_W-1:0]   core_cnt,
    output logic                rd_req,
    output logic                rd_is_sum,
    output logic [GRP_W-1:0]    rd_grp,
    output logic [IDX_W-1:0]    rd_idx,
    input  logic                rd_valid,
    input  logic [RD_W-1:0]     rd_data,
    output logic                vec_valid,
    input  logic                vec_ready,
    output logic [VEC_W-1:0]    vec_num,
    output logic                done,
    output logic [CNT_W-1:0]    done_count
);

    scan_state_e state_q, state_d;

    logic [GRP_W-1:0]         grp_q;
    logic [IDX_PER_GROUP-1:0] sum_q;
    logic [IDX_W-1:0]         idx_q;
    logic [BITS_PER_IDX-1:0]  bits_q;
    logic [BIT_W-1:0]         bit_q;
    logic [CNT_W-1:0]         cnt_q;

    logic             sum_found;
    logic [IDX_W-1:0] sum_pos;
    logic             bit_found;
    logic [BIT_W-1:0] bit_pos;
    logic             grp_bad;

    assign grp_bad = (req_grp >= GRP_IN_W'(NUM_GROUPS));

    msi_lsb_find #(.W(IDX_PER_GROUP)) u_idx_find (
        .vec   (sum_q),
        .found (sum_found),
        .pos   (sum_pos)
    );

    msi_lsb_find #(.W(BITS_PER_IDX)) u_bit_find (
        .vec   (bits_q),
        .found (bit_found),
        .pos   (bit_pos)
    );

    msi_vec_align #(
        .NUM_GROUPS    (NUM_GROUPS),
        .IDX_PER_GROUP (IDX_PER_GROUP),
        .BITS_PER_IDX  (BITS_PER_IDX),
        .MAX_CORES     (MAX_CORES)
    ) u_align (
        .grp      (grp_q),
        .idx      (idx_q),
        .bitn     (bit_q),
        .core_cnt (core_cnt),
        .vec_num  (vec_num)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (req_valid) state_d = grp_bad ? S_DONE : S_SUM_RD;
            S_SUM_RD:   if (rd_valid) state_d = S_PICK_IDX;
            S_PICK_IDX: state_d = sum_found ? S_IDX_RD : S_DONE;
            S_IDX_RD:   if (rd_valid) state_d = S_PICK_BIT;
            S_PICK_BIT: state_d = bit_found ? S_EMIT : S_PICK_IDX;
            S_EMIT:     if (vec_ready) state_d = S_PICK_BIT;
            S_DONE:     state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        req_ready  = (state_q == S_IDLE);
        rd_req     = (state_q == S_SUM_RD) || (state_q == S_IDX_RD);
        rd_is_sum  = (state_q == S_SUM_RD);
        rd_grp     = grp_q;
        rd_idx     = idx_q;
        vec_valid  = (state_q == S_EMIT);
        done       = (state_q == S_DONE);
        done_count = cnt_q;
    end

    // Scan datapath: local copies of the pending masks, cleared as handled
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grp_q  <= '0;
            sum_q  <= '0;
            idx_q  <= '0;
            bits_q <= '0;
            bit_q  <= '0;
            cnt_q  <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (req_valid) begin
                        grp_q <= req_grp[GRP_W-1:0];
                        cnt_q <= '0;
                        sum_q <= '0;
                    end
                end
                S_SUM_RD: begin
                    if (rd_valid) sum_q <= rd_data[IDX_PER_GROUP-1:0];
                end
                S_PICK_IDX: begin
                    if (sum_found) idx_q <= sum_pos;
                end
                S_IDX_RD: begin
                    if (rd_valid) bits_q <= rd_data[BITS_PER_IDX-1:0];
                end
                S_PICK_BIT: begin
                    if (bit_found) bit_q <= bit_pos;
                    else           sum_q[idx_q] <= 1'b0;
                end
                S_EMIT: begin
                    if (vec_ready) begin
                        bits_q[bit_q] <= 1'b0;
                        cnt_q         <= cnt_q + CNT_W'(1);
                    end
                end
                S_DONE: ;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/msi_pend_scan_chk.sv
module msi_pend_scan_chk #(
    parameter int NUM_GROUPS    = 16,
    parameter int IDX_PER_GROUP = 8,
    parameter int BITS_PER_IDX  = 16,
    parameter int MAX_CORES     = 8,
    parameter int GRP_IN_W      = 5,
    localparam int GRP_W  = $clog2(NUM_GROUPS),
    localparam int IDX_W  = $clog2(IDX_PER_GROUP),
    localparam int CORE_W = $clog2(MAX_CORES + 1),
    localparam int VEC_W  = $clog2(NUM_GROUPS * IDX_PER_GROUP * BITS_PER_IDX),
    localparam int CNT_W  = $clog2(IDX_PER_GROUP * BITS_PER_IDX + 1)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                req_ready,
    input logic [GRP_IN_W-1:0] req_grp,
    input logic [CORE_W-1:0]   core_cnt,
    input logic                rd_req,
    input logic                rd_is_sum,
    input logic [GRP_W-1:0]    rd_grp,
    input logic [IDX_W-1:0]    rd_idx,
    input logic                rd_valid,
    input logic                vec_valid,
    input logic                vec_ready,
    input logic [VEC_W-1:0]    vec_num,
    input logic                done,
    input logic [CNT_W-1:0]    done_count
);
    AST_BAD_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && (req_grp >= GRP_IN_W'(NUM_GROUPS)) |=> done && (done_count == '0)); // R1

    AST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid && (core_cnt != '0) |-> (vec_num % VEC_W'(core_cnt)) == '0); // R6

    AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid && !vec_ready |=> vec_valid && $stable(vec_num)); // R7

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !rd_valid |=> rd_req && $stable({rd_is_sum, rd_grp, rd_idx})); // R8

    AST_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
        !(vec_valid && rd_req)); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && req_ready); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !vec_valid && !rd_req && !done); // R9
endmodule

bind msi_pend_scan msi_pend_scan_chk #(
    .NUM_GROUPS    (NUM_GROUPS),
    .IDX_PER_GROUP (IDX_PER_GROUP),
    .BITS_PER_IDX  (BITS_PER_IDX),
    .MAX_CORES     (MAX_CORES),
    .GRP_IN_W      (GRP_IN_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_grp    (req_grp),
    .core_cnt   (core_cnt),
    .rd_req     (rd_req),
    .rd_is_sum  (rd_is_sum),
    .rd_grp     (rd_grp),
    .rd_idx     (rd_idx),
    .rd_valid   (rd_valid),
    .vec_valid  (vec_valid),
    .vec_ready  (vec_ready),
    .vec_num    (vec_num),
    .done       (done),
    .done_count (done_count)
);

// File: tb/msi_pend_scan_tb.sv
`timescale 1ns/1ps
module msi_pend_scan_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [4:0]  req_grp = '0;
    logic [3:0]  core_cnt = 4'd1;
    logic        rd_req;
    logic        rd_is_sum;
    logic [3:0]  rd_grp;
    logic [2:0]  rd_idx;
    logic        rd_valid = 1'b0;
    logic [15:0] rd_data = '0;
    logic        vec_valid;
    logic        vec_ready = 1'b0;
    logic [10:0] vec_num;
    logic        done;
    logic [7:0]  done_count;

    always #2.5 clk = ~clk;

    msi_pend_scan u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_grp(req_grp),
        .core_cnt(core_cnt),
        .rd_req(rd_req), .rd_is_sum(rd_is_sum), .rd_grp(rd_grp), .rd_idx(rd_idx),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .vec_valid(vec_valid), .vec_ready(vec_ready), .vec_num(vec_num),
        .done(done), .done_count(done_count)
    );

    int n_checks = 0;
    int n_fail   = 0;

    // Register bank model
    logic [7:0]  sum_mem [16];
    logic [15:0] idx_mem [16][8];

    // Expectations for the current scan
    int cur_g;
    int exp_v [128];
    int n_exp;
    int rd_exp_idx [8];
    int n_rd_exp;
    int rd_seen;
    int lat_max   = 0;
    int lat_cnt   = 0;
    int ready_pct = 100;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    function automatic int calc_vec(input int g, input int x, input int b, input int c);
        int raw;
        int ce;
        raw = ((x * 16) + b) * 16 + g;       // R5
        ce  = (c == 0) ? 1 : c;              // R6
        return raw - (raw % ce);
    endfunction

    // Read responder with variable latency
    initial begin
        forever begin
            @(negedge clk);
            rd_valid = 1'b0;
            if (rd_req) begin
                if (lat_cnt == 0) begin
                    if (rd_seen == 0)
                        chk(rd_is_sum && (int'(rd_grp) == cur_g), "R2 summary read first",
                            int'({rd_is_sum, rd_grp}), 16 + cur_g);
                    else
                        chk(!rd_is_sum && (int'(rd_grp) == cur_g) && (rd_seen <= 8) &&
                            (int'(rd_idx) == rd_exp_idx[(rd_seen <= 8) ? rd_seen - 1 : 0]),
                            "R3 index read order", int'(rd_idx),
                            rd_exp_idx[(rd_seen <= 8) ? rd_seen - 1 : 0]);
                    rd_data  = rd_is_sum ? {8'h00, sum_mem[rd_grp]} : idx_mem[rd_grp][rd_idx];
                    rd_valid = 1'b1;
                    rd_seen++;
                    lat_cnt  = (lat_max == 0) ? 0 : int'($urandom % (lat_max + 1));
                end else begin
                    lat_cnt--;
                end
            end
        end
    end

    task automatic run_scan(input int g, input int c);
        int n_got;
        bit stalled;
        logic [10:0] held;
        cur_g    = g;
        core_cnt = 4'(c);
        n_exp    = 0;
        n_rd_exp = 0;
        if (g < 16) begin
            n_rd_exp = 1;
            for (int x = 0; x < 8; x++) begin
                if (sum_mem[g][x]) begin
                    rd_exp_idx[n_rd_exp - 1] = x;
                    n_rd_exp++;
                    for (int b = 0; b < 16; b++)
                        if (idx_mem[g][x][b]) begin
                            exp_v[n_exp] = calc_vec(g, x, b, c);
                            n_exp++;
                        end
                end
            end
        end
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        rd_seen   = 0;
        lat_cnt   = (lat_max == 0) ? 0 : int'($urandom % (lat_max + 1));
        req_valid = 1'b1;
        req_grp   = 5'(g);
        @(negedge clk);
        req_valid = 1'b0;
        n_got   = 0;
        stalled = 1'b0;
        held    = '0;
        forever begin
            if (done) break;
            if (stalled)
                chk(vec_valid && (vec_num == held), "R7 stalled vector held",
                    int'(vec_num), int'(held));
            vec_ready = (int'($urandom % 100) < ready_pct);
            if (vec_valid && vec_ready) begin
                chk((n_got < n_exp) && (int'(vec_num) == exp_v[(n_got < 128) ? n_got : 0]),
                    "R4/R5/R6 vector value and order", int'(vec_num),
                    exp_v[(n_got < 128) ? n_got : 0]);
                n_got++;
            end
            stalled = vec_valid && !vec_ready;
            held    = vec_num;
            @(negedge clk);
        end
        vec_ready = 1'b0;
        chk(n_got == n_exp, "R4 vectors emitted", n_got, n_exp);
        chk(int'(done_count) == n_exp, "R9 done_count", int'(done_count), n_exp);
        chk(rd_seen == n_rd_exp, "R8 reads issued", rd_seen, n_rd_exp);
        if (g >= 16)
            chk(n_got == 0 && rd_seen == 0, "R1 out-of-range group quiet", n_got + rd_seen, 0);
        @(negedge clk);
        chk(!done && req_ready, "R9 single done pulse then idle", int'({done, req_ready}), 1);
    endtask

    task automatic clear_bank();
        for (int gg = 0; gg < 16; gg++) begin
            sum_mem[gg] = '0;
            for (int xx = 0; xx < 8; xx++) idx_mem[gg][xx] = '0;
        end
    endtask

    bit finished = 1'b0;

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = int'($urandom(32'd91357));
        clear_bank();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !vec_valid && !rd_req && !done, "R9 reset state",
            int'({req_ready, vec_valid, rd_req, done}), 8);

        // R1: out-of-range groups
        run_scan(16, 1);
        run_scan(31, 4);

        // R2/R3: empty summary, then a flagged index that reads zero
        run_scan(5, 1);
        sum_mem[7] = 8'b1001_0010;
        idx_mem[7][4] = 16'h8001;
        run_scan(7, 1);

        // R4/R5/R6: full group, widest numbers, several core counts
        sum_mem[15] = 8'hFF;
        for (int x = 0; x < 8; x++) idx_mem[15][x] = 16'hFFFF;
        run_scan(15, 8);
        run_scan(15, 3);
        run_scan(15, 0);

        // R7/R8: heavy back-pressure and read latency
        lat_max   = 4;
        ready_pct = 25;
        sum_mem[0] = 8'b0100_0001;
        idx_mem[0][0] = 16'h0021;
        idx_mem[0][6] = 16'h4000;
        run_scan(0, 5);

        // Random scans
        for (int t = 0; t < 60; t++) begin
            int g;
            g = int'($urandom % 16);
            sum_mem[g] = 8'($urandom & $urandom);
            for (int x = 0; x < 8; x++)
                idx_mem[g][x] = (($urandom % 5) == 0) ? 16'h0 : 16'($urandom & $urandom);
            lat_max   = int'($urandom % 4);
            ready_pct = 30 + int'($urandom % 71);
            run_scan(g, 1 + int'($urandom % 8));
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule